// File: doc/BRIEF.md
# NAND Read Sample-Delay Timing Solver

This block converts a set of nanosecond timing targets for a NAND flash bus into the quantized settings that a bus cycle generator needs. It produces data setup, data hold and address setup in clock cycles, a flag that drives the read-strobe delay line from half clock periods, and a sample delay factor in eighths (or sixteenths) of the reference period. When the device's read access and output hold times are known, the solver places the read sampling point near the centre of the data eye. It gives sample delay away for extra setup cycles wherever the delay line cannot reach the ideal point.

A job starts with a one-cycle `start` pulse while the solver is idle. All inputs are captured on that edge. The solver then works through a state machine that shares one sequential ceiling divider across every cycle conversion. It runs a set of bounded loops, each of which adds at most one setup cycle per step. When every loop has ended, the new settings appear on the outputs together with a one-cycle `done` pulse. They stay there until the next job finishes. When any device time is negative, a simpler fallback path is used: it trims a legacy sample delay one whole period at a time.

Top module: `nand_rd_timing_solver`

## Requirements
- R1: Hold cycles are ceil(hold_target / period) with a floor of 1. Address cycles are ceil(addr_target / period) with a floor of 0. Both saturate at 255.
- R2: Before conversion, the setup, hold and address targets each grow by 5 ns when `chip_count` is 2, and by 10 ns when it is 3 or more.
- R3: `half_period` is 1 exactly when the period is above 16 ns. The delay shift is 4 when it is set and 3 otherwise.
- R4: The maximum sample delay is 0 for periods above 32 ns. Otherwise it is min((15 × period) >> shift, 16). On the fallback path with a period above 32 ns and setup below 255, the sample factor therefore ends at 0.
- R5: If any of `t_rea_ns`, `t_rloh_ns` or `t_rhoh_ns` is negative, the fallback path is taken. The delay starts at `legacy_delay_ns`. While the delay exceeds the maximum and setup is below 255, each step adds one setup cycle and subtracts one period from the delay (clamped at 0). The factor is then ceil((delay << shift) / period), saturated at 15.
- R6: On the full path, the eye width is 5 + tRHOH + setup × period − 9 − tREA. Setup cycles are added until the eye width is positive or setup reaches 255.
- R7: On the full path, the ideal delay is (9 + tREA + 5 + tRHOH − setup × period) >> 1, clamped at 0. While it exceeds the maximum, each step adds a setup cycle and subtracts half a period. The factor is then derived as in R5. While |((factor × period) >> shift) − ideal| is greater than half the eye width, one of two steps is taken. If the quantized delay is late, the factor is decremented. If it is early, a setup cycle is added, the ideal delay is reduced by a half period plus a period (clamped at 0), and the factor is recomputed.
- R8: After reset, all outputs are 0. `done` is high for exactly one cycle per job, and the outputs change only in that cycle.
- R9: A `start` pulse that arrives while a job is in progress has no effect: no second result and no change to the running job.
- R10: Setup cycles on the outputs are always between 1 and 255, and the sample factor never exceeds 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a job; ignored while busy |
| period_ns | input | 8 | Bus clock period in ns (1 or more) |
| chip_count | input | 4 | Number of attached flash dies |
| setup_tgt_ns | input | 8 | Target data setup time |
| hold_tgt_ns | input | 8 | Target data hold time |
| addr_tgt_ns | input | 8 | Target address setup time |
| t_rea_ns | input | 8 | Signed read access time |
| t_rloh_ns | input | 8 | Signed output hold after strobe low |
| t_rhoh_ns | input | 8 | Signed output hold after strobe high |
| legacy_delay_ns | input | 8 | Sample delay used on the fallback path |
| done | output | 1 | One-cycle result strobe |
| setup_cyc | output | 8 | Data setup in cycles |
| hold_cyc | output | 8 | Data hold in cycles |
| addr_cyc | output | 8 | Address setup in cycles |
| half_period | output | 1 | Delay line runs from half periods |
| sample_factor | output | 4 | Sample delay factor |

## Verification
The assertions assume that the period is never zero, because the shared divider has no meaning for a zero divisor. They also assume that `start` is sampled on clean clock edges, with inputs held still around them. The stimulus draws periods from 1 ns upward and drives every input half a cycle away from the active edge. Device times and the fallback trigger are mixed so that both paths and the saturation corners are reached. The loops end either because of their own conditions or because setup reaches its ceiling of 255, so every job is bounded and the bench waits for each `done` with a cycle limit.

// File: rtl/nrt_pkg.sv
package nrt_pkg;

    localparam int PER_W   = 8;
    localparam int TGT_W   = 8;
    localparam int DEV_W   = 8;
    localparam int CHIP_W  = 4;
    localparam int CYC_W   = 8;
    localparam int SDF_W   = 4;
    localparam int ACC_W   = 24;
    localparam int DIV_W   = 16;
    localparam int SHF_W   = 3;

    localparam int CYC_MAX = (1 << CYC_W) - 1;
    localparam int SDF_MAX = (1 << SDF_W) - 1;

    localparam int MIN_PROP_NS    = 5;
    localparam int MAX_PROP_NS    = 9;
    localparam int DLL_PER_MAX_NS = 32;
    localparam int DLL_DLY_MAX_NS = 16;
    localparam int DERATE_TWO_NS  = 5;
    localparam int DERATE_MANY_NS = 10;
    localparam int SHIFT_FULL     = 3;

    typedef enum logic [3:0] {
        S_IDLE,
        S_DIV_GO,
        S_DIV_WAIT,
        S_FB_LOOP,
        S_EYE_INIT,
        S_EYE_OPEN,
        S_CENTER_INIT,
        S_CENTER,
        S_FIT,
        S_FIN
    } solver_state_t;

    typedef enum logic [2:0] {
        T_SETUP,
        T_HOLD,
        T_ADDR,
        T_SDF_FB,
        T_SDF_FIRST,
        T_SDF_REFIT
    } div_tag_t;

    typedef struct packed {
        logic [CYC_W-1:0] setup;
        logic [CYC_W-1:0] hold;
        logic [CYC_W-1:0] addr;
        logic             half;
        logic [SDF_W-1:0] sdf;
    } timing_res_t;

    function automatic logic [CYC_W-1:0] sat_cyc(input logic [DIV_W-1:0] q,
                                                 input logic floor_one);
        if (q > DIV_W'(CYC_MAX)) return CYC_W'(CYC_MAX);
        if (floor_one && q == '0) return CYC_W'(1);
        return q[CYC_W-1:0];
    endfunction

    function automatic logic [SDF_W-1:0] sat_sdf(input logic [DIV_W-1:0] q);
        if (q > DIV_W'(SDF_MAX)) return SDF_W'(SDF_MAX);
        return q[SDF_W-1:0];
    endfunction

    function automatic logic signed [ACC_W-1:0] clamp0(input logic signed [ACC_W-1:0] v);
        return (v < 0) ? '0 : v;
    endfunction

endpackage

// File: rtl/nrt_ceil_div.sv
module nrt_ceil_div
    import nrt_pkg::*;
#(
    parameter int NUM_W = DIV_W,
    parameter int DEN_W = PER_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             done,
    output logic [NUM_W-1:0] quo
);
    localparam int REM_W = DEN_W + 1;
    localparam int CNT_W = $clog2(NUM_W + 1);

    logic [NUM_W-1:0] work_q;
    logic [REM_W-1:0] rem_q;
    logic [DEN_W-1:0] den_q;
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic             done_q;

    logic [REM_W-1:0] rem_sh;
    logic             fits;
    logic [REM_W-1:0] rem_nx;

    always_comb begin
        rem_sh = {rem_q[REM_W-2:0], work_q[NUM_W-1]};
        fits   = rem_sh >= {1'b0, den_q};
        rem_nx = fits ? (rem_sh - {1'b0, den_q}) : rem_sh;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            work_q <= '0;
            rem_q  <= '0;
            den_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (go && !busy_q) begin
                // biasing by den-1 turns the floor quotient into a ceiling
                work_q <= num + {{(NUM_W-DEN_W){1'b0}}, den} - NUM_W'(1);
                rem_q  <= '0;
                den_q  <= den;
                cnt_q  <= CNT_W'(NUM_W);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                work_q <= {work_q[NUM_W-2:0], fits};
                rem_q  <= rem_nx;
                cnt_q  <= cnt_q - CNT_W'(1);
                if (cnt_q == CNT_W'(1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign done = done_q;
    assign quo  = work_q;

    // R1: the solver must never relaunch the shared divider mid-operation
    p_div_go_idle_r1: assert property (@(posedge clk) disable iff (rst)
        go |-> !busy_q);

    // R1: completion is a single-cycle strobe
    p_div_done_pulse_r1: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

endmodule

// File: rtl/nrt_limits.sv
module nrt_limits
    import nrt_pkg::*;
(
    input  logic [PER_W-1:0]  period,
    input  logic [CHIP_W-1:0] chips,
    input  logic [TGT_W-1:0]  setup_t,
    input  logic [TGT_W-1:0]  hold_t,
    input  logic [TGT_W-1:0]  addr_t,
    input  logic [DEV_W-1:0]  rea,
    input  logic [DEV_W-1:0]  rloh,
    input  logic [DEV_W-1:0]  rhoh,
    output logic [TGT_W:0]    setup_d,
    output logic [TGT_W:0]    hold_d,
    output logic [TGT_W:0]    addr_d,
    output logic              half,
    output logic [SHF_W-1:0]  shift,
    output logic [PER_W-1:0]  max_dly,
    output logic              full_path
);
    localparam int PROD_W = PER_W + SDF_W;

    logic [TGT_W:0]    derate;
    logic [PROD_W-1:0] span;
    logic [PROD_W-1:0] span_sh;

    always_comb begin
        if (chips > CHIP_W'(2))      derate = (TGT_W+1)'(DERATE_MANY_NS);
        else if (chips > CHIP_W'(1)) derate = (TGT_W+1)'(DERATE_TWO_NS);
        else                         derate = '0;

        setup_d = {1'b0, setup_t} + derate;
        hold_d  = {1'b0, hold_t}  + derate;
        addr_d  = {1'b0, addr_t}  + derate;

        half  = period > PER_W'(DLL_PER_MAX_NS / 2);
        shift = half ? SHF_W'(SHIFT_FULL + 1) : SHF_W'(SHIFT_FULL);

        span    = PROD_W'(SDF_MAX) * {{SDF_W{1'b0}}, period};
        span_sh = span >> shift;
        if (period > PER_W'(DLL_PER_MAX_NS))
            max_dly = '0;
        else if (span_sh > PROD_W'(DLL_DLY_MAX_NS))
            max_dly = PER_W'(DLL_DLY_MAX_NS);
        else
            max_dly = span_sh[PER_W-1:0];

        full_path = !rea[DEV_W-1] && !rloh[DEV_W-1] && !rhoh[DEV_W-1];
    end

endmodule

// File: rtl/nrt_quant.sv
module nrt_quant
    import nrt_pkg::*;
(
    input  logic [SDF_W-1:0]        sdf,
    input  logic [PER_W-1:0]        period,
    input  logic [SHF_W-1:0]        shift,
    input  logic signed [ACC_W-1:0] ideal,
    input  logic signed [ACC_W-1:0] eye,
    output logic                    late,
    output logic                    outside
);
    localparam int PROD_W = PER_W + SDF_W;

    logic [PROD_W-1:0]        prod;
    logic signed [ACC_W-1:0]  qdly;
    logic signed [ACC_W-1:0]  diff;
    logic signed [ACC_W-1:0]  err;
    logic signed [ACC_W-1:0]  half_eye;

    always_comb begin
        prod     = {{PER_W{1'b0}}, sdf} * {{SDF_W{1'b0}}, period};
        qdly     = {{(ACC_W-PROD_W){1'b0}}, prod >> shift};
        diff     = qdly - ideal;
        err      = (diff < 0) ? -diff : diff;
        half_eye = eye >>> 1;
        late     = diff > 0;
        outside  = err > half_eye;
    end

endmodule

// File: rtl/nand_rd_timing_solver.sv
module nand_rd_timing_solver
    import nrt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [7:0]        period_ns,
    input  logic [3:0]        chip_count,
    input  logic [7:0]        setup_tgt_ns,
    input  logic [7:0]        hold_tgt_ns,
    input  logic [7:0]        addr_tgt_ns,
    input  logic [7:0]        t_rea_ns,
    input  logic [7:0]        t_rloh_ns,
    input  logic [7:0]        t_rhoh_ns,
    input  logic [7:0]        legacy_delay_ns,
    output logic              done,
    output logic [7:0]        setup_cyc,
    output logic [7:0]        hold_cyc,
    output logic [7:0]        addr_cyc,
    output logic              half_period,
    output logic [3:0]        sample_factor
);
    localparam logic signed [ACC_W-1:0] MINP_S = ACC_W'(MIN_PROP_NS);
    localparam logic signed [ACC_W-1:0] MAXP_S = ACC_W'(MAX_PROP_NS);

    solver_state_t st_q;
    div_tag_t      tag_q;

    logic [PER_W-1:0]  per_q;
    logic [CHIP_W-1:0] chips_q;
    logic [TGT_W-1:0]  set_t_q, hold_t_q, addr_t_q, leg_q;
    logic [DEV_W-1:0]  rea_q, rloh_q, rhoh_q;

    logic [CYC_W-1:0]        setup_c, hold_c, addr_c;
    logic [SDF_W-1:0]        sdf_c;
    logic signed [ACC_W-1:0] ideal_q, sns_q, eye_q;

    timing_res_t res_q;
    logic        done_q;

    // derived limits
    logic [TGT_W:0]   setup_d, hold_d, addr_d;
    logic             half_w, full_path;
    logic [SHF_W-1:0] shift_w;
    logic [PER_W-1:0] max_dly;

    nrt_limits u_limits (
        .period    (per_q),
        .chips     (chips_q),
        .setup_t   (set_t_q),
        .hold_t    (hold_t_q),
        .addr_t    (addr_t_q),
        .rea       (rea_q),
        .rloh      (rloh_q),
        .rhoh      (rhoh_q),
        .setup_d   (setup_d),
        .hold_d    (hold_d),
        .addr_d    (addr_d),
        .half      (half_w),
        .shift     (shift_w),
        .max_dly   (max_dly),
        .full_path (full_path)
    );

    logic late_w, outside_w;

    nrt_quant u_quant (
        .sdf     (sdf_c),
        .period  (per_q),
        .shift   (shift_w),
        .ideal   (ideal_q),
        .eye     (eye_q),
        .late    (late_w),
        .outside (outside_w)
    );

    // shared divider
    logic             div_go, div_done;
    logic [DIV_W-1:0] div_num, div_quo;
    logic [ACC_W-1:0] ideal_sh;

    always_comb begin
        ideal_sh = ideal_q << shift_w;
        unique case (tag_q)
            T_SETUP: div_num = {{(DIV_W-TGT_W-1){1'b0}}, setup_d};
            T_HOLD:  div_num = {{(DIV_W-TGT_W-1){1'b0}}, hold_d};
            T_ADDR:  div_num = {{(DIV_W-TGT_W-1){1'b0}}, addr_d};
            default: div_num = ideal_sh[DIV_W-1:0];
        endcase
        div_go = (st_q == S_DIV_GO);
    end

    nrt_ceil_div #(.NUM_W(DIV_W), .DEN_W(PER_W)) u_div (
        .clk  (clk),
        .rst  (rst),
        .go   (div_go),
        .num  (div_num),
        .den  (per_q),
        .done (div_done),
        .quo  (div_quo)
    );

    // signed views of the working operands
    logic signed [ACC_W-1:0]   per_s, half_per_s, max_s, rea_s, rhoh_s, leg_s;
    logic [PER_W+CYC_W-1:0]    sns_prod;
    logic signed [ACC_W-1:0]   sns_init, eye_init, center_raw;
    logic                      can_grow;

    always_comb begin
        per_s      = {{(ACC_W-PER_W){1'b0}}, per_q};
        half_per_s = per_s >>> 1;
        max_s      = {{(ACC_W-PER_W){1'b0}}, max_dly};
        rea_s      = {{(ACC_W-DEV_W){rea_q[DEV_W-1]}}, rea_q};
        rhoh_s     = {{(ACC_W-DEV_W){rhoh_q[DEV_W-1]}}, rhoh_q};
        leg_s      = {{(ACC_W-TGT_W){1'b0}}, leg_q};
        sns_prod   = {{CYC_W{1'b0}}, per_q} * {{PER_W{1'b0}}, setup_c};
        sns_init   = {{(ACC_W-PER_W-CYC_W){1'b0}}, sns_prod};
        eye_init   = MINP_S + rhoh_s + sns_init - MAXP_S - rea_s;
        center_raw = (MAXP_S + rea_s + MINP_S + rhoh_s - sns_q) >>> 1;
        can_grow   = setup_c < CYC_W'(CYC_MAX);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= S_IDLE;
            tag_q    <= T_SETUP;
            per_q    <= '0;
            chips_q  <= '0;
            set_t_q  <= '0;
            hold_t_q <= '0;
            addr_t_q <= '0;
            leg_q    <= '0;
            rea_q    <= '0;
            rloh_q   <= '0;
            rhoh_q   <= '0;
            setup_c  <= '0;
            hold_c   <= '0;
            addr_c   <= '0;
            sdf_c    <= '0;
            ideal_q  <= '0;
            sns_q    <= '0;
            eye_q    <= '0;
            res_q    <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (st_q)
                S_IDLE: begin
                    if (start) begin
                        per_q    <= period_ns;
                        chips_q  <= chip_count;
                        set_t_q  <= setup_tgt_ns;
                        hold_t_q <= hold_tgt_ns;
                        addr_t_q <= addr_tgt_ns;
                        leg_q    <= legacy_delay_ns;
                        rea_q    <= t_rea_ns;
                        rloh_q   <= t_rloh_ns;
                        rhoh_q   <= t_rhoh_ns;
                        tag_q    <= T_SETUP;
                        st_q     <= S_DIV_GO;
                    end
                end
                S_DIV_GO: st_q <= S_DIV_WAIT;
                S_DIV_WAIT: begin
                    if (div_done) begin
                        unique case (tag_q)
                            T_SETUP: begin
                                setup_c <= sat_cyc(div_quo, 1'b1);
                                tag_q   <= T_HOLD;
                                st_q    <= S_DIV_GO;
                            end
                            T_HOLD: begin
                                hold_c <= sat_cyc(div_quo, 1'b1);
                                tag_q  <= T_ADDR;
                                st_q   <= S_DIV_GO;
                            end
                            T_ADDR: begin
                                addr_c <= sat_cyc(div_quo, 1'b0);
                                if (full_path) begin
                                    st_q <= S_EYE_INIT;
                                end else begin
                                    ideal_q <= leg_s;
                                    st_q    <= S_FB_LOOP;
                                end
                            end
                            T_SDF_FB: begin
                                sdf_c <= sat_sdf(div_quo);
                                st_q  <= S_FIN;
                            end
                            default: begin
                                sdf_c <= sat_sdf(div_quo);
                                st_q  <= S_FIT;
                            end
                        endcase
                    end
                end
                S_FB_LOOP: begin
                    if (ideal_q > max_s && can_grow) begin
                        setup_c <= setup_c + CYC_W'(1);
                        ideal_q <= clamp0(ideal_q - per_s);
                    end else begin
                        tag_q <= T_SDF_FB;
                        st_q  <= S_DIV_GO;
                    end
                end
                S_EYE_INIT: begin
                    sns_q <= sns_init;
                    eye_q <= eye_init;
                    st_q  <= S_EYE_OPEN;
                end
                S_EYE_OPEN: begin
                    if (eye_q <= 0 && can_grow) begin
                        setup_c <= setup_c + CYC_W'(1);
                        sns_q   <= sns_q + per_s;
                        eye_q   <= eye_q + per_s;
                    end else begin
                        st_q <= S_CENTER_INIT;
                    end
                end
                S_CENTER_INIT: begin
                    ideal_q <= clamp0(center_raw);
                    st_q    <= S_CENTER;
                end
                S_CENTER: begin
                    if (ideal_q > max_s && can_grow) begin
                        setup_c <= setup_c + CYC_W'(1);
                        sns_q   <= sns_q + per_s;
                        eye_q   <= eye_q + per_s;
                        ideal_q <= clamp0(ideal_q - half_per_s);
                    end else begin
                        tag_q <= T_SDF_FIRST;
                        st_q  <= S_DIV_GO;
                    end
                end
                S_FIT: begin
                    if (outside_w && can_grow) begin
                        if (late_w) begin
                            if (sdf_c != '0) sdf_c <= sdf_c - SDF_W'(1);
                        end else begin
                            setup_c <= setup_c + CYC_W'(1);
                            sns_q   <= sns_q + per_s;
                            eye_q   <= eye_q + per_s;
                            ideal_q <= clamp0(ideal_q - half_per_s - per_s);
                            tag_q   <= T_SDF_REFIT;
                            st_q    <= S_DIV_GO;
                        end
                    end else begin
                        st_q <= S_FIN;
                    end
                end
                S_FIN: begin
                    res_q.setup <= setup_c;
                    res_q.hold  <= hold_c;
                    res_q.addr  <= addr_c;
                    res_q.half  <= half_w;
                    res_q.sdf   <= sdf_c;
                    done_q      <= 1'b1;
                    st_q        <= S_IDLE;
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end

    assign done          = done_q;
    assign setup_cyc     = res_q.setup;
    assign hold_cyc      = res_q.hold;
    assign addr_cyc      = res_q.addr;
    assign half_period   = res_q.half;
    assign sample_factor = res_q.sdf;

    // R8: result strobe lasts one cycle
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R8: published settings only move together with the strobe
    p_out_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !$stable(res_q) |-> done_q);

    // R9: captured job parameters stay frozen while a job runs
    p_inputs_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        (st_q != S_IDLE) |=> ($stable(per_q) && $stable(rea_q) && $stable(leg_q)));

    // R10: published setup lies inside its legal range
    p_setup_range_r10: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (res_q.setup >= CYC_W'(1)));

    // R3: published half-period flag agrees with the captured period
    p_half_flag_r3: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (res_q.half == (per_q > PER_W'(DLL_PER_MAX_NS / 2))));

    // R6: setup only ever grows while the full-path loops run
    p_setup_monotone_r6: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_EYE_OPEN || st_q == S_CENTER || st_q == S_FIT)
        |=> (setup_c >= $past(setup_c)));

endmodule

// File: tb/sim_nand_rd_timing_solver.sv
module sim_nand_rd_timing_solver;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [7:0] period_ns = 8'd10;
    logic [3:0] chip_count = 4'd1;
    logic [7:0] setup_tgt_ns = '0, hold_tgt_ns = '0, addr_tgt_ns = '0;
    logic [7:0] t_rea_ns = '0, t_rloh_ns = '0, t_rhoh_ns = '0;
    logic [7:0] legacy_delay_ns = '0;
    logic       done;
    logic [7:0] setup_cyc, hold_cyc, addr_cyc;
    logic       half_period;
    logic [3:0] sample_factor;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    int got_set, got_hold, got_addr, got_half, got_sdf;

    always #4 clk = ~clk;
    always @(posedge clk) cycles <= cycles + 1;

    nand_rd_timing_solver u0 (
        .clk(clk), .rst(rst), .start(start),
        .period_ns(period_ns), .chip_count(chip_count),
        .setup_tgt_ns(setup_tgt_ns), .hold_tgt_ns(hold_tgt_ns), .addr_tgt_ns(addr_tgt_ns),
        .t_rea_ns(t_rea_ns), .t_rloh_ns(t_rloh_ns), .t_rhoh_ns(t_rhoh_ns),
        .legacy_delay_ns(legacy_delay_ns),
        .done(done), .setup_cyc(setup_cyc), .hold_cyc(hold_cyc), .addr_cyc(addr_cyc),
        .half_period(half_period), .sample_factor(sample_factor)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int cdiv(input int x, input int p);
        return (x + p - 1) / p;
    endfunction

    function automatic int sat255(input int v, input int lo);
        if (v < lo) return lo;
        if (v > 255) return 255;
        return v;
    endfunction

    function automatic int sdf_of(input int ideal, input int sh, input int p);
        int f = cdiv(ideal << sh, p);
        return (f > 15) ? 15 : f;
    endfunction

    // independent model of R1..R7
    task automatic model(input int p, input int ch, input int s, input int h, input int a,
                         input int rea, input int rloh, input int rhoh, input int leg,
                         output int es, output int eh, output int ea,
                         output int ehalf, output int esdf, output int full);
        int der, sh, maxd, ideal, sns, eye, q, diff;
        der   = (ch > 2) ? 10 : ((ch > 1) ? 5 : 0);
        es    = sat255(cdiv(s + der, p), 1);
        eh    = sat255(cdiv(h + der, p), 1);
        ea    = sat255(cdiv(a + der, p), 0);
        ehalf = (p > 16) ? 1 : 0;
        sh    = ehalf ? 4 : 3;
        if (p > 32) maxd = 0;
        else begin
            maxd = (15 * p) >> sh;
            if (maxd > 16) maxd = 16;
        end
        full = (rea >= 0 && rloh >= 0 && rhoh >= 0) ? 1 : 0;
        if (!full) begin
            ideal = leg;
            while (ideal > maxd && es < 255) begin
                es++;
                ideal -= p;
                if (ideal < 0) ideal = 0;
            end
            esdf = sdf_of(ideal, sh, p);
        end else begin
            sns = p * es;
            eye = 5 + rhoh + sns - 9 - rea;
            while (eye <= 0 && es < 255) begin
                es++; sns += p; eye += p;
            end
            ideal = (9 + rea + 5 + rhoh - sns) >>> 1;
            if (ideal < 0) ideal = 0;
            while (ideal > maxd && es < 255) begin
                es++; sns += p; eye += p;
                ideal -= p >> 1;
                if (ideal < 0) ideal = 0;
            end
            esdf = sdf_of(ideal, sh, p);
            forever begin
                q = (esdf * p) >> sh;
                diff = q - ideal;
                if (!(((diff < 0) ? -diff : diff) > (eye >>> 1) && es < 255)) break;
                if (q > ideal) begin
                    if (esdf != 0) esdf--;
                end else begin
                    es++; sns += p; eye += p;
                    ideal = ideal - (p >> 1) - p;
                    if (ideal < 0) ideal = 0;
                    esdf = sdf_of(ideal, sh, p);
                end
            end
        end
    endtask

    task automatic apply(input int p, input int ch, input int s, input int h, input int a,
                         input int rea, input int rloh, input int rhoh, input int leg);
        period_ns = 8'(p); chip_count = 4'(ch);
        setup_tgt_ns = 8'(s); hold_tgt_ns = 8'(h); addr_tgt_ns = 8'(a);
        t_rea_ns = 8'(rea); t_rloh_ns = 8'(rloh); t_rhoh_ns = 8'(rhoh);
        legacy_delay_ns = 8'(leg);
    endtask

    // returns 1 when done was seen within the limit
    task automatic wait_done(output int ok);
        int n = 0;
        ok = 0;
        while (n < 30000) begin
            @(negedge clk);
            n++;
            if (done) begin ok = 1; break; end
        end
        if (!ok) chk("R8", "watchdog expired waiting for done", 0, 1);
    endtask

    task automatic run_job(input int p, input int ch, input int s, input int h, input int a,
                           input int rea, input int rloh, input int rhoh, input int leg);
        int es, eh, ea, ehalf, esdf, full, ok;
        model(p, ch, s, h, a, rea, rloh, rhoh, leg, es, eh, ea, ehalf, esdf, full);
        @(negedge clk);
        apply(p, ch, s, h, a, rea, rloh, rhoh, leg);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(ok);
        got_set = setup_cyc; got_hold = hold_cyc; got_addr = addr_cyc;
        got_half = half_period; got_sdf = sample_factor;
        if (!ok) return;
        chk(full ? "R6" : "R5", "setup cycles", setup_cyc, es);
        chk("R1", "hold cycles", hold_cyc, eh);
        chk("R1", "address cycles", addr_cyc, ea);
        chk("R3", "half period", half_period, ehalf);
        chk(full ? "R7" : "R5", "sample factor", sample_factor, esdf);
        chk("R10", "setup lower bound", (setup_cyc >= 1) ? 1 : 0, 1);
        if (full && setup_cyc < 255)
            chk("R6", "eye open", (5 + rhoh + p * setup_cyc - 9 - rea > 0) ? 1 : 0, 1);
        @(negedge clk);
        chk("R8", "done width", done, 0);
    endtask

    initial begin : watchdog
        #1500000;
        chk("R8", "global watchdog", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        int seed;
        int ok;
        seed = $urandom(20240611);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8: reset state
        chk("R8", "done after reset", done, 0);
        chk("R8", "setup after reset", setup_cyc, 0);
        chk("R8", "factor after reset", sample_factor, 0);

        // R1: floors at zero targets
        run_job(10, 1, 0, 0, 0, 20, 5, 5, 0);
        chk("R1", "hold floor", got_hold, 1);
        chk("R1", "address floor", got_addr, 0);
        // R1 / R10: saturation at period 1
        run_job(1, 3, 250, 255, 255, 10, 3, 3, 0);
        chk("R1", "hold saturates", got_hold, 255);
        chk("R10", "setup ceiling", got_set, 255);

        // R2: chip derating, hold target 20 at period 10
        run_job(10, 1, 20, 20, 20, 20, 5, 5, 0);
        chk("R2", "one chip hold", got_hold, 2);
        run_job(10, 2, 20, 20, 20, 20, 5, 5, 0);
        chk("R2", "two chips hold", got_hold, 3);
        run_job(10, 5, 20, 21, 20, 20, 5, 5, 0);
        chk("R2", "many chips hold", got_hold, 4);

        // R3: half-period boundary
        run_job(16, 1, 10, 10, 10, 20, 5, 5, 0);
        chk("R3", "period 16", got_half, 0);
        run_job(17, 1, 10, 10, 10, 20, 5, 5, 0);
        chk("R3", "period 17", got_half, 1);

        // R4 / R5: slow clock on the fallback path forces factor 0
        run_job(33, 1, 10, 10, 10, -1, 5, 5, 70);
        chk("R4", "slow clock factor", got_sdf, 0);
        // R5: fallback with delay inside the limit and trimmed delay
        run_job(20, 1, 15, 10, 5, 12, -3, 4, 5);
        run_job(20, 1, 15, 10, 5, 12, 4, -2, 60);

        // R6 / R7: late access time and tight setup
        run_job(10, 1, 0, 5, 5, 60, 0, 0, 0);
        run_job(25, 2, 5, 5, 5, 30, 5, 15, 0);
        run_job(8, 1, 12, 6, 6, 18, 4, 6, 0);

        // R9: a second start during a job is ignored
        begin
            int es, eh, ea, ehalf, esdf, full;
            model(12, 1, 20, 10, 10, 22, 5, 6, 0, es, eh, ea, ehalf, esdf, full);
            @(negedge clk);
            apply(12, 1, 20, 10, 10, 22, 5, 6, 0);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (3) @(negedge clk);
            apply(40, 4, 200, 200, 200, -5, 0, 0, 200);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            wait_done(ok);
            chk("R9", "setup of first job", setup_cyc, es);
            chk("R9", "hold of first job", hold_cyc, eh);
            ok = 0;
            repeat (400) begin
                @(negedge clk);
                if (done) ok = 1;
            end
            chk("R9", "no second result", ok, 0);
        end

        // random mix of both paths
        for (int i = 0; i < 150; i++) begin
            int p, rea, rloh, rhoh;
            p    = 1 + int'($urandom % 40);
            rea  = int'($urandom % 45);
            rloh = int'($urandom % 10);
            rhoh = int'($urandom % 25);
            if ($urandom % 5 == 0) rloh = -1 - int'($urandom % 4);
            if ($urandom % 9 == 0) rea  = -1;
            run_job(p, 1 + int'($urandom % 4), int'($urandom % 64), int'($urandom % 64),
                    int'($urandom % 64), rea, rloh, rhoh, int'($urandom % 48));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule